// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block sits on the host side of a 12-bit serial analog-to-digital converter. It owns the converter's active-low convert-start strobe and its serial clock. It captures the converter's serial data line into a parallel 12-bit word. A command port accepts one of three requests: a normal conversion, entry into partial power-down, or entry into full power-down. The controller shapes the frame for each request. The frame length and the point where the strobe is released tell the converter which power mode to enter, so the frame is not a fixed-length read.

After reset the controller runs one full conversion on its own so that the converter can calibrate itself. It throws away the result of that conversion. Before each new strobe falling edge it also enforces the minimum acquisition time, counted from the edge on which the converter returns to tracking. Each completed normal result is held in a one-entry output register with a valid/ready handshake. A sticky flag reports a result that was overwritten before it was accepted.

Top module: `adc_readout`

## Requirements
- R1: While reset is asserted and right after it, the strobe is high, the serial clock is low, `sampleValid` is 0 and `overrun` is 0.
- R2: After reset, and before `cmdReady` first rises, the controller runs one normal frame of 16 serial clock rising edges without any command. Its result never appears on `sampleValid`.
- R3: A normal conversion (`cmdOp` = 0) drives the strobe low and produces 16 serial clock rising edges. The strobe is released on the falling edge after the 16th. The bits sampled at rising edges 4 through 15 form the result, most significant bit first, on `sampleData`.
- R4: The serial clock idles low. Its period is 2·HALF_DIV system cycles, and its first rising edge comes HALF_DIV cycles after the strobe falls. No rising edge occurs while the strobe is high.
- R5: A partial power-down request (`cmdOp` = 1) produces a frame of exactly 8 rising edges. The strobe rises after the 8th edge and before a 9th, and no sample is reported.
- R6: A full power-down request (`cmdOp` = 2) produces two back-to-back 8-edge frames, and no sample is reported.
- R7: `cmdOp` = 3 is treated as a normal conversion.
- R8: In a normal frame, the next strobe falling edge comes at least max(ACQ_CYC, MIN_ACQ_CYC) system cycles after the 14th serial clock rising edge.
- R9: `busy` is high whenever the strobe is low, and it stays high until the acquisition gap ends. `cmdReady` is low while `busy` is high.
- R10: Once `sampleValid` is high, it and `sampleData` stay unchanged until a cycle with `sampleReady` high, unless a newer result arrives.
- R11: If a new result completes while the previous one is valid and `sampleReady` is low, the new result replaces the old one and `overrun` is set. `overrun` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command request |
| cmdOp | input | 2 | 0 normal, 1 partial power-down, 2 full power-down, 3 normal |
| cmdReady | output | 1 | Command accepted when high together with cmdValid |
| adcCnvstN | output | 1 | Active-low convert-start strobe to the converter |
| adcSclk | output | 1 | Serial clock to the converter |
| adcDout | input | 1 | Serial data from the converter |
| sampleValid | output | 1 | Result available |
| sampleReady | input | 1 | Consumer takes the result |
| sampleData | output | 12 | Conversion result |
| busy | output | 1 | Frame or acquisition gap in progress |
| overrun | output | 1 | Sticky: a result was overwritten before it was accepted |

## Verification
The assertions assume that the converter shifts each new bit out on a serial clock falling edge and keeps the line steady until the next falling edge. They also assume that `cmdOp` is stable whenever `cmdValid` is high. The bench's behavioural converter shifts only on falling edges, and it drives the line high while the strobe is high, so any capture outside a frame would corrupt a result. Commands and `sampleReady` change only on the falling system clock edge, so every handshake input is settled before the edge that samples it.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

  // command codes on cmdOp
  localparam logic [1:0] OP_NORMAL = 2'd0;
  localparam logic [1:0] OP_NAP    = 2'd1;
  localparam logic [1:0] OP_SLEEP  = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic shift;  // capture adcDout into the result shifter
    logic push;   // move the finished word to the output register
  } dpCtl_t;

endpackage

// File: rtl/adcrd_ctrl.sv
module adcrd_ctrl
  import adcrd_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int LEAD_ZEROS  = 3,
  parameter int FRAME_LEN   = 16,
  parameter int PD_LEN      = 8,
  parameter int TRACK_EDGE  = 14,
  parameter int HALF_DIV    = 2,
  parameter int ACQ_CYC     = 25,
  parameter int MIN_ACQ_CYC = 25
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  output logic       cmdReady,
  output logic       adcCnvstN,
  output logic       adcSclk,
  output logic       busy,
  output dpCtl_t     dpCtl
);

  localparam int EDGE_W  = $clog2(FRAME_LEN + 1);
  localparam int DIV_W   = $clog2(HALF_DIV + 1);
  localparam int ACQ_EFF = (ACQ_CYC > MIN_ACQ_CYC) ? ACQ_CYC : MIN_ACQ_CYC;
  localparam int ACQ_W   = $clog2(ACQ_EFF + 1);
  localparam logic [EDGE_W-1:0] FULL_E  = EDGE_W'(FRAME_LEN);
  localparam logic [EDGE_W-1:0] SHORT_E = EDGE_W'(PD_LEN);
  localparam logic [EDGE_W-1:0] TRACK_E = EDGE_W'(TRACK_EDGE - 1);
  localparam logic [EDGE_W-1:0] LEAD_E  = EDGE_W'(LEAD_ZEROS);
  localparam logic [EDGE_W-1:0] DEND_E  = EDGE_W'(LEAD_ZEROS + DATA_W);
  localparam logic [DIV_W-1:0]  DIV_TOP = DIV_W'(HALF_DIV - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_ACQ} ctlSt_t;

  ctlSt_t              state;
  logic [DIV_W-1:0]    divCnt;
  logic [EDGE_W-1:0]   edgeCnt;
  logic [ACQ_W-1:0]    acqLeft;
  logic                shortFrame, discard, calPend, fpdPend;
  logic                tick, riseNow, fallNow, lastFall, trackEdge, acqLoad;
  logic                startOk, startCal, startFpd2, cmdFire, startAny, newShort;

  always_comb begin
    tick      = (state == ST_SHIFT) && (divCnt == DIV_TOP);
    riseNow   = tick && !adcSclk;
    fallNow   = tick && adcSclk;
    lastFall  = fallNow && (edgeCnt == (shortFrame ? SHORT_E : FULL_E));
    trackEdge = riseNow && !shortFrame && (edgeCnt == TRACK_E);
    acqLoad   = trackEdge || (lastFall && shortFrame);
    startOk   = (state == ST_IDLE) && (acqLeft == '0);
    startCal  = startOk && calPend;
    startFpd2 = startOk && !calPend && fpdPend;
    cmdReady  = startOk && !calPend && !fpdPend;
    cmdFire   = cmdValid && cmdReady;
    startAny  = startCal || startFpd2 || cmdFire;
    newShort  = startFpd2 || (cmdFire && (cmdOp == OP_NAP || cmdOp == OP_SLEEP));
    dpCtl.shift = riseNow && (edgeCnt >= LEAD_E) && (edgeCnt < DEND_E);
    dpCtl.push  = lastFall && !shortFrame && !discard;
    busy        = (state != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      adcCnvstN  <= 1'b1;
      adcSclk    <= 1'b0;
      divCnt     <= '0;
      edgeCnt    <= '0;
      acqLeft    <= '0;
      shortFrame <= 1'b0;
      discard    <= 1'b0;
      calPend    <= 1'b1;
      fpdPend    <= 1'b0;
    end else begin
      if (acqLoad)            acqLeft <= ACQ_W'(ACQ_EFF);
      else if (acqLeft != '0) acqLeft <= acqLeft - ACQ_W'(1);
      case (state)
        ST_IDLE: if (startAny) begin
          state      <= ST_SHIFT;
          adcCnvstN  <= 1'b0;
          divCnt     <= '0;
          edgeCnt    <= '0;
          shortFrame <= newShort;
          discard    <= startCal;
          if (startCal)  calPend <= 1'b0;
          if (startFpd2) fpdPend <= 1'b0;
          if (cmdFire && cmdOp == OP_SLEEP) fpdPend <= 1'b1;
        end
        ST_SHIFT: begin
          if (tick) begin
            divCnt  <= '0;
            adcSclk <= !adcSclk;
            if (riseNow) edgeCnt <= edgeCnt + EDGE_W'(1);
            if (lastFall) begin
              adcCnvstN <= 1'b1;
              state     <= ST_ACQ;
            end
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        ST_ACQ: if (acqLeft == '0) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // assertion-side counter: cycles since the last tracking edge
  logic [ACQ_W:0] sinceTrack;
  logic           trackSeen;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceTrack <= '0;
      trackSeen  <= 1'b0;
    end else if (trackEdge) begin
      sinceTrack <= '0;
      trackSeen  <= 1'b1;
    end else if (sinceTrack != '1) begin
      sinceTrack <= sinceTrack + (ACQ_W+1)'(1);
    end
  end

  p_acq_gap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (trackSeen && $fell(adcCnvstN)) |-> (sinceTrack >= (ACQ_W+1)'(ACQ_EFF)));

  p_capture_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.shift |-> (!adcCnvstN && !adcSclk));

  p_busy_frame_r9: assert property (@(posedge clk) disable iff (!rstN)
    !adcCnvstN |-> (busy && !cmdReady));

  p_frame_len_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(adcCnvstN) && !shortFrame) |-> (edgeCnt == FULL_E));

  p_pd_window_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(adcCnvstN) && shortFrame) |-> (edgeCnt > EDGE_W'(3) && edgeCnt <= TRACK_E));

endmodule

// File: rtl/adcrd_dpath.sv
module adcrd_dpath
  import adcrd_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic              adcDout,
  input  logic              sampleReady,
  output logic              sampleValid,
  output logic [DATA_W-1:0] sampleData,
  output logic              overrun
);

  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN)            shiftReg <= '0;
    else if (dpCtl.shift) shiftReg <= {shiftReg[DATA_W-2:0], adcDout};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleValid <= 1'b0;
      sampleData  <= '0;
      overrun     <= 1'b0;
    end else if (dpCtl.push) begin
      sampleValid <= 1'b1;
      sampleData  <= shiftReg;
      if (sampleValid && !sampleReady) overrun <= 1'b1;
    end else if (sampleValid && sampleReady) begin
      sampleValid <= 1'b0;
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !sampleReady && !dpCtl.push) |=> (sampleValid && $stable(sampleData)));

  p_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

endmodule

// File: rtl/adc_readout.sv
module adc_readout
  import adcrd_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int LEAD_ZEROS  = 3,
  parameter int FRAME_LEN   = 16,
  parameter int PD_LEN      = 8,
  parameter int TRACK_EDGE  = 14,
  parameter int HALF_DIV    = 2,
  parameter int ACQ_CYC     = 25,
  parameter int MIN_ACQ_CYC = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  output logic              cmdReady,
  output logic              adcCnvstN,
  output logic              adcSclk,
  input  logic              adcDout,
  output logic              sampleValid,
  input  logic              sampleReady,
  output logic [DATA_W-1:0] sampleData,
  output logic              busy,
  output logic              overrun
);

  dpCtl_t dpCtl;

  adcrd_ctrl #(
    .DATA_W(DATA_W), .LEAD_ZEROS(LEAD_ZEROS), .FRAME_LEN(FRAME_LEN),
    .PD_LEN(PD_LEN), .TRACK_EDGE(TRACK_EDGE), .HALF_DIV(HALF_DIV),
    .ACQ_CYC(ACQ_CYC), .MIN_ACQ_CYC(MIN_ACQ_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdReady(cmdReady), .adcCnvstN(adcCnvstN), .adcSclk(adcSclk),
    .busy(busy), .dpCtl(dpCtl)
  );

  adcrd_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .adcDout(adcDout),
    .sampleReady(sampleReady), .sampleValid(sampleValid),
    .sampleData(sampleData), .overrun(overrun)
  );

endmodule

// File: tb/adc_readout_tb.sv
`timescale 1ns/1ps
module adc_readout_tb;
  localparam int HALF_DIV = 2;
  localparam int ACQ_EFF  = 25;
  localparam int CLK_NS   = 5;

  logic clk = 1'b0, rstN = 1'b0, cmdValid = 1'b0, sampleReady = 1'b0;
  logic [1:0] cmdOp = 2'd0;
  logic cmdReady, adcCnvstN, adcSclk, adcDout, sampleValid, busy, overrun;
  logic [11:0] sampleData;

  always #2.5 clk = ~clk;

  adc_readout #(.HALF_DIV(HALF_DIV), .ACQ_CYC(ACQ_EFF), .MIN_ACQ_CYC(ACQ_EFF)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdReady(cmdReady),
    .adcCnvstN(adcCnvstN), .adcSclk(adcSclk), .adcDout(adcDout),
    .sampleValid(sampleValid), .sampleReady(sampleReady), .sampleData(sampleData),
    .busy(busy), .overrun(overrun)
  );

  // behavioural converter: bit index advances on each falling serial clock edge
  logic [11:0] anaVal = 12'h000, heldVal = 12'h000;
  int bitIdx = 0;
  function automatic logic modelBit(int i, logic [11:0] v);
    if (i >= 3 && i <= 14) return v[14 - i];
    return 1'b0;
  endfunction
  always @(negedge adcCnvstN) begin heldVal = anaVal; bitIdx = 0; end
  always @(negedge adcSclk) if (!adcCnvstN) bitIdx++;
  assign adcDout = adcCnvstN ? 1'b1 : modelBit(bitIdx, heldVal); // released line seen as 1

  // frame monitor
  int frameEdges = 0, frameCount = 0, lastEdges = 0;
  int firstRiseBad = 0, periodBad = 0, strayRise = 0, busyBad = 0;
  time tFall = 0, tLastRise = 0, t14 = 0, minGap = 1_000_000;
  bit seen14 = 0;
  always @(negedge adcCnvstN) begin
    if (seen14 && ($time - t14) < minGap) minGap = $time - t14;
    seen14 = 0; frameEdges = 0; frameCount++; tFall = $time;
  end
  always @(posedge adcSclk) begin
    if (adcCnvstN) strayRise++;
    frameEdges++;
    if (frameEdges == 1 && ($time - tFall) != HALF_DIV * CLK_NS) firstRiseBad++;
    if (frameEdges > 1 && ($time - tLastRise) != 2 * HALF_DIV * CLK_NS) periodBad++;
    tLastRise = $time;
    if (frameEdges == 14) begin seen14 = 1; t14 = $time; end
  end
  always @(posedge adcCnvstN) lastEdges = frameEdges;
  always @(negedge clk) if (rstN && ((!adcCnvstN && !busy) || (busy && cmdReady))) busyBad++;

  int nChecks = 0, nErr = 0;
  task automatic check(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitReady();
    while (!cmdReady) @(negedge clk);
  endtask

  task automatic issue(logic [1:0] op);
    waitReady();
    cmdOp = op; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic accept();
    sampleReady = 1'b1;
    @(negedge clk);
    sampleReady = 1'b0;
  endtask

  // {op, analog value, expected number of frames}
  localparam int NV = 9;
  localparam logic [15:0] VECS [NV] = '{
    {2'd0, 12'hA5C, 2'd1}, {2'd0, 12'h000, 2'd1}, {2'd0, 12'hFFF, 2'd1},
    {2'd1, 12'h3C3, 2'd1}, {2'd0, 12'h801, 2'd1}, {2'd2, 12'h7E7, 2'd2},
    {2'd0, 12'h123, 2'd1}, {2'd3, 12'h5AA, 2'd1}, {2'd0, 12'h001, 2'd1}
  };

  initial begin
    #500_000;
    nErr++; nChecks++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check(adcCnvstN && !adcSclk && !sampleValid && !overrun, "R1 reset outputs",
          {adcCnvstN, adcSclk, sampleValid, overrun}, 4'b1000);
    rstN = 1'b1;
    @(negedge clk);
    check(!cmdReady, "R2 no command during calibration", cmdReady, 0);
    // R2 calibration frame runs alone and its result is dropped
    anaVal = 12'hBEE;
    waitReady();
    check(frameCount == 1 && lastEdges == 16, "R2 calibration frame", frameCount * 100 + lastEdges, 116);
    check(!sampleValid, "R2 calibration result discarded", sampleValid, 0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op; logic [11:0] val; int nf; int f0;
      op = VECS[i][15:14]; val = VECS[i][13:2]; nf = int'(VECS[i][1:0]);
      anaVal = val; f0 = frameCount;
      issue(op);
      waitReady();
      check(frameCount - f0 == nf, "R6 frames per request", frameCount - f0, nf);
      if (op == 2'd1 || op == 2'd2) begin
        check(lastEdges == 8, "R5 power-down frame edges", lastEdges, 8);
        check(!sampleValid, "R5 power-down yields no sample", sampleValid, 0);
      end else begin
        check(lastEdges == 16, "R3 normal frame edges", lastEdges, 16);
        check(sampleValid && sampleData == val, op == 2'd3 ? "R7 op3 result" : "R3 result",
              sampleData, val);
        accept();
        check(!sampleValid, "R10 cleared after accept", sampleValid, 0);
      end
    end

    // R10 hold while not ready, R11 overrun replaces and sticks
    anaVal = 12'h456;
    issue(2'd0);
    waitReady();
    repeat (5) @(negedge clk);
    check(sampleValid && sampleData == 12'h456, "R10 held while not ready", sampleData, 12'h456);
    check(!overrun, "R11 no overrun yet", overrun, 0);
    anaVal = 12'h9AB;
    issue(2'd0);
    waitReady();
    check(overrun && sampleData == 12'h9AB, "R11 overrun and replace", {overrun, sampleData}, 13'h19AB);
    accept();
    check(overrun && !sampleValid, "R11 overrun sticky", {overrun, sampleValid}, 2'b10);

    // timing monitors
    check(minGap >= ACQ_EFF * CLK_NS, "R8 acquisition gap ns", int'(minGap), ACQ_EFF * CLK_NS);
    check(firstRiseBad == 0 && periodBad == 0, "R4 serial clock timing", firstRiseBad + periodBad, 0);
    check(strayRise == 0, "R4 no clock with strobe high", strayRise, 0);
    check(busyBad == 0, "R9 busy and ready", busyBad, 0);

    // R1 reset again clears overrun and valid
    rstN = 1'b0;
    @(negedge clk); @(negedge clk);
    check(adcCnvstN && !adcSclk && !sampleValid && !overrun, "R1 re-reset outputs",
          {adcCnvstN, adcSclk, sampleValid, overrun}, 4'b1000);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule